// File: doc/BRIEF.md
# Digital Potentiometer Register Bank

This block holds the register state of a single-channel, 256-position digital potentiometer. A volatile wiper register drives an 8-bit tap-select output (00h selects the low end of the resistor chain, FFh the high end). Beside it sits a non-volatile image: an initial-value byte, five general-purpose bytes and a fixed identification byte. A one-bit volatility control decides whether location 0 reaches the wiper or the initial-value byte. The non-volatile image is modelled as flops that a soft reset does not touch. A separate factory-clear input loads the programmed defaults into them.

A bus front end reaches the bank through a plain port: an address, a sequential-access flag, a write strobe and write data. The bank answers in the same cycle with read data and an accept flag. Writes take effect on the clock edge that samples the strobe.

A two-state sequencer handles power-up:
- `PH_MIDSCALE` is entered on reset. The wiper is held at midscale and every access is rejected.
- The transition `recall` is taken on the first edge with `recall_en` high. It copies the initial value into the wiper and enters `PH_READY`.
- `PH_READY` is left only through reset, which is the transition `reset_to_midscale`.

Top module: `potbank_top`

## Requirements
- R1: While `rst_n` is low and after its release, `tap_sel` is 80h and the volatility bit reads 0, until a recall occurs.
- R2: In the midscale phase every access is rejected: `acc_ok` is 0, `acc_rdata` is 00h and writes change nothing. The first edge with `recall_en` high loads the initial value into the wiper and enters the ready phase. After that, `recall_en` has no effect.
- R3: With the volatility bit at 0, a write to address 00h updates both the initial value and the wiper on the same edge. A read of 00h returns the initial value.
- R4: With the volatility bit at 1, a write to address 00h updates only the wiper. A read of 00h returns the wiper. The initial value is unchanged.
- R5: Address 08h holds the volatility bit in bit 7; bits 6..0 read 0. A write of 00h or 80h is accepted. Any other value still stores bit 7, but `acc_ok` is 0.
- R6: Address 01h reads D0h. A write to it is accepted and changes nothing.
- R7: Addresses 02h..06h are general-purpose bytes that read back what was written.
- R8: When address 07h is selected directly (`acc_seq`=0), it is rejected and reads 00h. When it is reached with `acc_seq`=1, a read is accepted and returns FFh. A write to 07h is always rejected. Addresses 09h and above are rejected, and writes to them change nothing.
- R9: The initial value and the general-purpose bytes keep their contents across `rst_n`. The wiper returns to 80h, and the next recall restores the stored initial value.
- R10: While `nv_clear_n` is low, the initial value is set to 80h and the general-purpose bytes to 00h. The wiper is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous; volatile state only |
| nv_clear_n | input | 1 | Factory clear of the non-volatile image, active low, asynchronous |
| recall_en | input | 1 | Non-volatile contents readable; starts the recall |
| acc_addr | input | 8 | Register address |
| acc_seq | input | 1 | Address reached by auto-increment rather than direct selection |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the current address |
| acc_ok | output | 1 | Access accepted |
| tap_sel | output | 8 | Wiper tap selection |

## Verification
Each fault in this bank has a port where it shows:
- A wiper that loads from the wrong source shows on `tap_sel` one edge after the offending write or recall.
- An initial-value byte that was wrongly updated or wrongly protected shows only when location 0 is read with the volatility bit at 0. Alternatively, it shows after a soft reset and recall, when `tap_sel` exposes the stored byte.
- A decode fault shows at once, combinationally, in `acc_ok` and `acc_rdata` for the address involved.
- Lost general-purpose contents after a soft reset appear on the first read of those bytes.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
    typedef enum logic {
        PH_MIDSCALE = 1'b0,
        PH_READY    = 1'b1
    } phase_t;

    typedef enum logic [2:0] {
        SEL_LOC0,
        SEL_ID,
        SEL_GP,
        SEL_RSV,
        SEL_ACR,
        SEL_BAD
    } sel_t;
endpackage

// File: rtl/potbank_seq.sv
module potbank_seq
    import potbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   recall_en,
    output phase_t phase,
    output logic   ready,
    output logic   recall_load
);
    phase_t phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_MIDSCALE: if (recall_en) phase_d = PH_READY;
            PH_READY:    phase_d = PH_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_MIDSCALE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        ready       = 1'b0;
        recall_load = 1'b0;
        unique case (phase_q)
            PH_MIDSCALE: recall_load = recall_en;
            PH_READY:    ready       = 1'b1;
        endcase
    end

    assign phase = phase_q;
endmodule

// File: rtl/potbank_decode.sv
module potbank_decode
    import potbank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int GP_COUNT = 5,
    parameter int IDX_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              seq,
    input  logic              wr,
    input  logic [DATA_W-2:0] wdata_low,
    input  logic              vol,
    input  logic              ready,
    output sel_t              sel,
    output logic [IDX_W-1:0]  gp_idx,
    output logic              ok,
    output logic              we_ivr,
    output logic              we_wiper,
    output logic              we_gp,
    output logic              we_acr
);
    localparam int GP_BASE = 2;
    localparam logic [ADDR_W-1:0] A_LOC0 = '0;
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_GP   = ADDR_W'(GP_BASE);
    localparam logic [ADDR_W-1:0] A_RSV  = ADDR_W'(GP_BASE + GP_COUNT);
    localparam logic [ADDR_W-1:0] A_ACR  = ADDR_W'(GP_BASE + GP_COUNT + 1);

    logic [ADDR_W-1:0] offs;
    logic              hit_ok;
    logic              live_wr;

    assign offs    = addr - A_GP;
    assign live_wr = wr && ready;

    always_comb begin
        sel    = SEL_BAD;
        gp_idx = '0;
        if (addr == A_LOC0)                     sel = SEL_LOC0;
        else if (addr == A_ID)                  sel = SEL_ID;
        else if (offs < ADDR_W'(GP_COUNT)) begin
            sel    = SEL_GP;
            gp_idx = IDX_W'(offs);
        end
        else if (addr == A_RSV)                 sel = SEL_RSV;
        else if (addr == A_ACR)                 sel = SEL_ACR;
    end

    always_comb begin
        hit_ok = 1'b0;
        unique case (sel)
            SEL_LOC0, SEL_ID, SEL_GP: hit_ok = 1'b1;
            SEL_RSV:                  hit_ok = seq && !wr;
            SEL_ACR:                  hit_ok = !wr || (wdata_low == '0);
            default:                  hit_ok = 1'b0;
        endcase
    end

    assign ok       = hit_ok && ready;
    assign we_wiper = live_wr && (sel == SEL_LOC0);
    assign we_ivr   = live_wr && (sel == SEL_LOC0) && !vol;
    assign we_gp    = live_wr && (sel == SEL_GP);
    assign we_acr   = live_wr && (sel == SEL_ACR);
endmodule

// File: rtl/potbank_nvstore.sv
module potbank_nvstore #(
    parameter int          DATA_W      = 8,
    parameter int          GP_COUNT    = 5,
    parameter int          IDX_W       = 3,
    parameter logic [7:0]  IVR_DEFAULT = 8'h80
) (
    input  logic                       clk,
    input  logic                       nv_clear_n,
    input  logic                       we_ivr,
    input  logic                       we_gp,
    input  logic [IDX_W-1:0]           gp_idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          ivr_q,
    output logic [GP_COUNT*DATA_W-1:0] gp_flat
);
    always_ff @(posedge clk or negedge nv_clear_n) begin
        if (!nv_clear_n) ivr_q <= DATA_W'(IVR_DEFAULT);
        else if (we_ivr) ivr_q <= wdata;
    end

    for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
        always_ff @(posedge clk or negedge nv_clear_n) begin
            if (!nv_clear_n)
                gp_flat[g*DATA_W +: DATA_W] <= '0;
            else if (we_gp && (gp_idx == IDX_W'(g)))
                gp_flat[g*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/potbank_top.sv
module potbank_top
    import potbank_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter int         GP_COUNT    = 5,
    parameter logic [7:0] ID_VALUE    = 8'hD0,
    parameter logic [7:0] IVR_DEFAULT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_clear_n,
    input  logic              recall_en,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_seq,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_ok,
    output logic [DATA_W-1:0] tap_sel
);
    localparam int                IDX_W = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1;
    localparam logic [DATA_W-1:0] MID   = DATA_W'(1) << (DATA_W - 1);

    phase_t                     phase;
    sel_t                       sel;
    logic                       ready, recall_load;
    logic [IDX_W-1:0]           gp_idx;
    logic                       we_ivr, we_wiper, we_gp, we_acr;
    logic [DATA_W-1:0]          ivr_q, wiper_q;
    logic [GP_COUNT*DATA_W-1:0] gp_flat;
    logic                       vol_q;

    potbank_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .recall_en   (recall_en),
        .phase       (phase),
        .ready       (ready),
        .recall_load (recall_load)
    );

    potbank_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .GP_COUNT (GP_COUNT),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr      (acc_addr),
        .seq       (acc_seq),
        .wr        (acc_wr),
        .wdata_low (acc_wdata[DATA_W-2:0]),
        .vol       (vol_q),
        .ready     (ready),
        .sel       (sel),
        .gp_idx    (gp_idx),
        .ok        (acc_ok),
        .we_ivr    (we_ivr),
        .we_wiper  (we_wiper),
        .we_gp     (we_gp),
        .we_acr    (we_acr)
    );

    potbank_nvstore #(
        .DATA_W      (DATA_W),
        .GP_COUNT    (GP_COUNT),
        .IDX_W       (IDX_W),
        .IVR_DEFAULT (IVR_DEFAULT)
    ) u_nv (
        .clk        (clk),
        .nv_clear_n (nv_clear_n),
        .we_ivr     (we_ivr),
        .we_gp      (we_gp),
        .gp_idx     (gp_idx),
        .wdata      (acc_wdata),
        .ivr_q      (ivr_q),
        .gp_flat    (gp_flat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           wiper_q <= MID;
        else if (recall_load) wiper_q <= ivr_q;
        else if (we_wiper)    wiper_q <= acc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vol_q <= 1'b0;
        else if (we_acr) vol_q <= acc_wdata[DATA_W-1];
    end

    always_comb begin
        acc_rdata = '0;
        if (ready) begin
            unique case (sel)
                SEL_LOC0: acc_rdata = vol_q ? wiper_q : ivr_q;
                SEL_ID:   acc_rdata = DATA_W'(ID_VALUE);
                SEL_GP:   acc_rdata = gp_flat[int'(gp_idx)*DATA_W +: DATA_W];
                SEL_RSV:  acc_rdata = acc_seq ? '1 : '0;
                SEL_ACR:  acc_rdata = {vol_q, {(DATA_W-1){1'b0}}};
                default:  acc_rdata = '0;
            endcase
        end
    end

    assign tap_sel = wiper_q;
endmodule

// File: rtl/potbank_top_chk.sv
module potbank_top_chk
    import potbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_clear_n,
    input logic              recall_en,
    input phase_t            phase,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              acc_ok,
    input logic [DATA_W-1:0] tap_sel,
    input logic [DATA_W-1:0] ivr_q,
    input logic              vol_q
);
    localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W - 1);
    localparam logic [ADDR_W-1:0] A_ACR = ADDR_W'(8);

    // R1
    midscale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MIDSCALE) |-> (tap_sel == MID));

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clear_n)
        (phase == PH_MIDSCALE && recall_en) |=> (tap_sel == $past(ivr_q)));

    // R2
    early_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MIDSCALE) |-> !acc_ok);

    // R3
    loc0_both_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clear_n)
        (phase == PH_READY && acc_wr && acc_addr == '0 && !vol_q)
        |=> (tap_sel == $past(acc_wdata)) && (ivr_q == $past(acc_wdata)));

    // R4
    loc0_wiper_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clear_n)
        (phase == PH_READY && acc_wr && acc_addr == '0 && vol_q)
        |=> (tap_sel == $past(acc_wdata)) && $stable(ivr_q));

    // R5
    acr_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr == A_ACR && acc_ok) |-> (acc_rdata[DATA_W-2:0] == '0));

    // R8
    high_addr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr > A_ACR) |-> !acc_ok);
endmodule

bind potbank_top potbank_top_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_clear_n (nv_clear_n),
    .recall_en  (recall_en),
    .phase      (phase),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .acc_ok     (acc_ok),
    .tap_sel    (tap_sel),
    .ivr_q      (ivr_q),
    .vol_q      (vol_q)
);

// File: tb/potbank_top_tb_top.sv
module potbank_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 34;

    logic       clk = 1'b0;
    logic       rst_n, nv_clear_n, recall_en;
    logic [7:0] acc_addr, acc_wdata, acc_rdata, tap_sel;
    logic       acc_seq, acc_wr, acc_ok;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    potbank_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nv_clear_n (nv_clear_n),
        .recall_en  (recall_en),
        .acc_addr   (acc_addr),
        .acc_seq    (acc_seq),
        .acc_wr     (acc_wr),
        .acc_wdata  (acc_wdata),
        .acc_rdata  (acc_rdata),
        .acc_ok     (acc_ok),
        .tap_sel    (tap_sel)
    );

    // {addr, seq, wr, wdata, exp_rdata (before edge), exp_ok, exp_tap (after edge), req}
    localparam logic [38:0] VEC [NVEC] = '{
        {8'h01,1'b0,1'b0,8'h00,8'hD0,1'b1,8'h80,4'd6},  // R6 id read
        {8'h01,1'b0,1'b1,8'hAA,8'hD0,1'b1,8'h80,4'd6},  // R6 write accepted
        {8'h01,1'b0,1'b0,8'h00,8'hD0,1'b1,8'h80,4'd6},  // R6 unchanged
        {8'h02,1'b0,1'b0,8'h00,8'h00,1'b1,8'h80,4'd7},  // R7 default, early write lost
        {8'h02,1'b0,1'b1,8'h5A,8'h00,1'b1,8'h80,4'd7},  // R7
        {8'h06,1'b0,1'b1,8'hA5,8'h00,1'b1,8'h80,4'd7},  // R7 top gp byte
        {8'h02,1'b0,1'b0,8'h00,8'h5A,1'b1,8'h80,4'd7},  // R7
        {8'h06,1'b0,1'b0,8'h00,8'hA5,1'b1,8'h80,4'd7},  // R7
        {8'h08,1'b0,1'b0,8'h00,8'h00,1'b1,8'h80,4'd5},  // R5 vol default 0
        {8'h00,1'b0,1'b1,8'h3C,8'h80,1'b1,8'h3C,4'd3},  // R3 both updated
        {8'h00,1'b0,1'b0,8'h00,8'h3C,1'b1,8'h3C,4'd3},  // R3 ivr read
        {8'h08,1'b0,1'b1,8'h80,8'h00,1'b1,8'h3C,4'd5},  // R5 set vol
        {8'h08,1'b0,1'b0,8'h00,8'h80,1'b1,8'h3C,4'd5},  // R5
        {8'h00,1'b0,1'b0,8'h00,8'h3C,1'b1,8'h3C,4'd4},  // R4 wiper read
        {8'h00,1'b0,1'b1,8'hC3,8'h3C,1'b1,8'hC3,4'd4},  // R4 wiper only
        {8'h00,1'b0,1'b0,8'h00,8'hC3,1'b1,8'hC3,4'd4},  // R4
        {8'h08,1'b0,1'b1,8'h00,8'h80,1'b1,8'hC3,4'd5},  // R5 clear vol
        {8'h00,1'b0,1'b0,8'h00,8'h3C,1'b1,8'hC3,4'd4},  // R4 ivr kept
        {8'h08,1'b0,1'b1,8'h81,8'h00,1'b0,8'hC3,4'd5},  // R5 odd value rejected
        {8'h08,1'b0,1'b0,8'h00,8'h80,1'b1,8'hC3,4'd5},  // R5 bit 7 stored
        {8'h00,1'b0,1'b0,8'h00,8'hC3,1'b1,8'hC3,4'd5},  // R5 vol takes effect
        {8'h08,1'b0,1'b1,8'h7F,8'h80,1'b0,8'hC3,4'd5},  // R5 rejected, stores 0
        {8'h08,1'b0,1'b0,8'h00,8'h00,1'b1,8'hC3,4'd5},  // R5
        {8'h07,1'b0,1'b0,8'h00,8'h00,1'b0,8'hC3,4'd8},  // R8 direct reserved
        {8'h07,1'b1,1'b0,8'h00,8'hFF,1'b1,8'hC3,4'd8},  // R8 sequential reserved
        {8'h07,1'b1,1'b1,8'h12,8'hFF,1'b0,8'hC3,4'd8},  // R8 write reserved
        {8'h09,1'b0,1'b0,8'h00,8'h00,1'b0,8'hC3,4'd8},  // R8
        {8'hFF,1'b0,1'b0,8'h00,8'h00,1'b0,8'hC3,4'd8},  // R8
        {8'h0C,1'b0,1'b1,8'h11,8'h00,1'b0,8'hC3,4'd8},  // R8 write out of range
        {8'h00,1'b0,1'b0,8'h00,8'h3C,1'b1,8'hC3,4'd8},  // R8 nothing changed
        {8'h00,1'b0,1'b1,8'h00,8'h3C,1'b1,8'h00,4'd3},  // R3 low end
        {8'h08,1'b0,1'b1,8'h80,8'h00,1'b1,8'h00,4'd5},  // R5
        {8'h00,1'b0,1'b1,8'hFF,8'h00,1'b1,8'hFF,4'd4},  // R4 high end
        {8'h00,1'b0,1'b0,8'h00,8'hFF,1'b1,8'hFF,4'd4}   // R4
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp,
                         input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // drive at falling edge; rdata/ok checked before the write edge, tap after it
    task automatic access(input logic [7:0] a, input logic s, input logic w,
                          input logic [7:0] d, input logic [7:0] erd, input logic eok,
                          input logic [7:0] etap, input int req);
        @(negedge clk);
        acc_addr = a; acc_seq = s; acc_wr = w; acc_wdata = d;
        #1;
        check(acc_rdata, erd, req, "rdata");
        check({7'd0, acc_ok}, {7'd0, eok}, req, "ok");
        @(posedge clk);
        #1;
        check(tap_sel, etap, req, "tap");
        acc_wr = 1'b0; acc_seq = 1'b0;
    endtask

    task automatic do_recall(input logic [7:0] etap, input int req);
        @(negedge clk);
        recall_en = 1'b1;
        @(posedge clk);
        #1;
        check(tap_sel, etap, req, "tap after recall");
        @(negedge clk);
        recall_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; nv_clear_n = 1'b0; recall_en = 1'b0;
        acc_addr = '0; acc_seq = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
        repeat (2) @(negedge clk);
        #1;
        check(tap_sel, 8'h80, 1, "tap in reset");                   // R1
        nv_clear_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(tap_sel, 8'h80, 1, "tap midscale");                   // R1
        // R2: accesses rejected before recall, write dropped
        access(8'h08, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80, 2);
        access(8'h02, 1'b0, 1'b1, 8'h55, 8'h00, 1'b0, 8'h80, 2);
        access(8'h00, 1'b0, 1'b1, 8'h11, 8'h00, 1'b0, 8'h80, 2);
        do_recall(8'h80, 2);                                        // R2 recall of default

        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][38:31], VEC[i][30], VEC[i][29], VEC[i][28:21],
                   VEC[i][20:13], VEC[i][12], VEC[i][11:4], int'(VEC[i][3:0]));
        end
        // state now: ivr=00, wiper=FF, vol=1, gp2=5A, gp6=A5

        // R9: soft reset keeps the non-volatile image
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(tap_sel, 8'h80, 9, "tap in soft reset");
        @(negedge clk);
        rst_n = 1'b1;
        access(8'h08, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80, 9);   // R9 still midscale
        do_recall(8'h00, 9);                                        // R9 stored ivr restored
        access(8'h08, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 9);   // R9 vol back to 0
        access(8'h02, 1'b0, 1'b0, 8'h00, 8'h5A, 1'b1, 8'h00, 9);
        access(8'h06, 1'b0, 1'b0, 8'h00, 8'hA5, 1'b1, 8'h00, 9);

        // R2: recall_en ignored once ready
        access(8'h08, 1'b0, 1'b1, 8'h80, 8'h00, 1'b1, 8'h00, 2);
        access(8'h00, 1'b0, 1'b1, 8'h44, 8'h00, 1'b1, 8'h44, 2);
        do_recall(8'h44, 2);

        // R10: factory clear reloads defaults, wiper untouched
        @(negedge clk);
        nv_clear_n = 1'b0;
        @(negedge clk);
        nv_clear_n = 1'b1;
        access(8'h08, 1'b0, 1'b1, 8'h00, 8'h80, 1'b1, 8'h44, 10);
        access(8'h00, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 8'h44, 10);
        access(8'h02, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h44, 10);
        access(8'h06, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h44, 10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule